// File: doc/BRIEF.md
# Width-Configurable Bus Beat Sequencer

This block sits between the load/store and fetch side of a processor core and a split-transaction system bus. It turns each accepted request into one address tenure and, unless the request is address-only, one data tenure made of one or more beats. A strap input sampled while reset is held sets the data path to 32 or 64 bits for the rest of the run. The beat count and the bytes per beat follow from that width and from the request kind: a noncached access, a noncached double-word access, a full 32-byte line fill or writeback, or an address-only operation.

Address and data tenures are sequenced independently. A following request may open and close its address tenure while the current data tenure is still moving beats. The block keeps at most one acknowledged but unstarted data tenure in reserve, and starts it in the cycle after the running data tenure reports completion. Burst beats walk the line critical-word-first and wrap inside the 32-byte line.

Top module: `bus_beat_seq`

## Requirements
- R1: The data width is captured from `width_sel` while `rst_n` is low (0 = 32-bit, 1 = 64-bit). Changes on `width_sel` after reset release have no effect on beat counts or beat sizes.
- R2: `d_bytes` gives the bytes moved by the current beat. A noncached access with `req_dw` = 0 carries `req_len`+1 bytes (1 to 4). Double-word and line beats carry 4 bytes in 32-bit mode and 8 bytes in 64-bit mode.
- R3: A line request (`req_kind` = 1) produces 8 beats in 32-bit mode and 4 beats in 64-bit mode, moving 32 bytes in total.
- R4: A noncached request (`req_kind` = 0) produces one beat when `req_dw` = 0. With `req_dw` = 1 it produces two beats in 32-bit mode and one beat in 64-bit mode.
- R5: The first beat of a line sits at `req_addr` rounded down to the beat width, and the first beat of a double-word access at `req_addr` rounded down to 8. Each later beat adds the beat width to bits 4:0 modulo 32 and leaves the upper address bits unchanged. A single noncached beat uses `req_addr` unchanged.
- R6: An address-only request (`req_kind` = 2 or 3) opens no data tenure. `adone` pulses for one cycle, in the cycle after `aack`.
- R7: `ts` is high for exactly one cycle, in the cycle after a request is accepted (`req_valid` and `req_ready` both high). During that cycle `a_addr` equals the accepted `req_addr`.
- R8: A new request is accepted while a data tenure is active, and its address tenure can be acknowledged before that data tenure ends.
- R9: Once an address is acknowledged while a data tenure is active, `req_ready` stays low until the waiting tenure starts. The waiting tenure's first beat appears in the cycle after `ddone`.
- R10: `ddone` pulses for one cycle, in the cycle after the last `ta`, with `d_active` low in that cycle.
- R11: After reset, `req_ready` is high and `ts`, `d_active`, `ddone` and `adone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the width strap is captured while low |
| width_sel | input | 1 | Width strap: 0 = 32-bit data path, 1 = 64-bit data path |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 0 noncached, 1 line, 2 or 3 address-only |
| req_dw | input | 1 | Noncached access spans 8 bytes |
| req_len | input | 2 | Bytes minus one for a noncached access narrower than 8 bytes |
| req_write | input | 1 | Write when high, read when low |
| req_addr | input | 32 | Request byte address |
| ts | output | 1 | Transfer-start pulse on the first address-tenure cycle |
| a_addr | output | 32 | Address-tenure address |
| a_kind | output | 2 | Address-tenure request kind |
| a_write | output | 1 | Address-tenure direction |
| aack | input | 1 | Address acknowledge, closes the address tenure |
| d_active | output | 1 | Data tenure in progress |
| d_addr | output | 32 | Address of the current beat |
| d_bytes | output | 4 | Byte count of the current beat |
| d_write | output | 1 | Direction of the current data tenure |
| ta | input | 1 | Per-beat acknowledge |
| ddone | output | 1 | Data tenure finished pulse |
| adone | output | 1 | Address-only request finished pulse |

## Verification
A wrong beat counter shows on the ports within the tenure it corrupts: `d_active` stays high past the last expected beat, or `ddone` arrives early, and a bench that drives exactly the expected number of acknowledges catches either at the next negative edge. A wrong wrap or step in the beat address shows on `d_addr` at the very next beat, so every beat of every burst is compared. A lost or misrouted reserve tenure shows as `req_ready` going high too early or as the second data tenure starting at the wrong address in the cycle after `ddone`. A width captured at the wrong time shows as the wrong beat count on the first line transfer after the strap is toggled.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    localparam logic [1:0] KIND_NC   = 2'd0;
    localparam logic [1:0] KIND_LINE = 2'd1;
    // any kind with bit 1 set is address-only
    localparam int KIND_AONLY_BIT = 1;
endpackage

// File: rtl/bbs_plan.sv
module bbs_plan #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int CW         = 4
) (
    input  logic          wide,
    input  logic [1:0]    kind,
    input  logic          dw,
    input  logic [1:0]    len,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] first_addr,
    output logic [CW-1:0] nbeats,
    output logic [3:0]    bytes,
    output logic          burst
);
    import bbs_pkg::*;

    localparam logic [CW-1:0] NB_NARROW = CW'(LINE_BYTES / 4);
    localparam logic [CW-1:0] NB_WIDE   = CW'(LINE_BYTES / 8);

    logic is_line;
    logic is_aonly;
    logic [3:0] step_bytes;

    always_comb begin
        is_line    = (kind == KIND_LINE);
        is_aonly   = kind[KIND_AONLY_BIT];
        step_bytes = wide ? 4'd8 : 4'd4;
        burst      = is_line || dw;

        if (is_line) begin
            first_addr = wide ? {addr[AW-1:3], 3'b000} : {addr[AW-1:2], 2'b00};
        end else if (dw) begin
            first_addr = {addr[AW-1:3], 3'b000};
        end else begin
            first_addr = addr;
        end

        if (is_aonly) begin
            nbeats = '0;
        end else if (is_line) begin
            nbeats = wide ? NB_WIDE : NB_NARROW;
        end else if (dw && !wide) begin
            nbeats = CW'(2);
        end else begin
            nbeats = CW'(1);
        end

        bytes = burst ? step_bytes : {2'b00, len} + 4'd1;
    end
endmodule

// File: rtl/bbs_step.sv
module bbs_step #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          wide,
    input  logic          burst,
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [OFF_W-1:0] off_next;

    always_comb begin
        off_next  = cur_addr[OFF_W-1:0] + (wide ? OFF_W'(8) : OFF_W'(4));
        next_addr = burst ? {cur_addr[AW-1:OFF_W], off_next} : cur_addr;
    end
endmodule

// File: rtl/bus_beat_seq.sv
module bus_beat_seq #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          width_sel,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic          req_dw,
    input  logic [1:0]    req_len,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          ts,
    output logic [AW-1:0] a_addr,
    output logic [1:0]    a_kind,
    output logic          a_write,
    input  logic          aack,
    output logic          d_active,
    output logic [AW-1:0] d_addr,
    output logic [3:0]    d_bytes,
    output logic          d_write,
    input  logic          ta,
    output logic          ddone,
    output logic          adone
);
    import bbs_pkg::*;

    localparam int CW = $clog2(LINE_BYTES / 4) + 1;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic [3:0]    bytes;
        logic          write;
        logic          burst;
    } tenure_t;

    typedef struct packed {
        logic          wide;
        logic          a_busy;
        logic          a_first;
        logic [AW-1:0] a_addr;
        logic [1:0]    a_kind;
        logic          a_write;
        logic          a_dw;
        logic [1:0]    a_len;
        logic          pend_v;
        tenure_t       pend;
        logic          d_busy;
        tenure_t       dat;
        logic          ddone;
        logic          adone;
    } state_t;

    state_t s_d, s_q;

    logic [AW-1:0] plan_addr;
    logic [CW-1:0] plan_beats;
    logic [3:0]    plan_bytes;
    logic          plan_burst;
    logic [AW-1:0] step_addr;
    tenure_t       plan_t;
    logic          accept;

    bbs_plan #(.AW(AW), .LINE_BYTES(LINE_BYTES), .CW(CW)) u_plan (
        .wide       (s_q.wide),
        .kind       (s_q.a_kind),
        .dw         (s_q.a_dw),
        .len        (s_q.a_len),
        .addr       (s_q.a_addr),
        .first_addr (plan_addr),
        .nbeats     (plan_beats),
        .bytes      (plan_bytes),
        .burst      (plan_burst)
    );

    bbs_step #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_step (
        .wide      (s_q.wide),
        .burst     (s_q.dat.burst),
        .cur_addr  (s_q.dat.addr),
        .next_addr (step_addr)
    );

    always_comb begin
        plan_t    = '{addr: plan_addr, left: plan_beats, bytes: plan_bytes,
                      write: s_q.a_write, burst: plan_burst};
        req_ready = !s_q.a_busy && !s_q.pend_v;
        accept    = req_valid && req_ready;

        s_d         = s_q;
        s_d.a_first = 1'b0;
        s_d.ddone   = 1'b0;
        s_d.adone   = 1'b0;

        // address tenure
        if (accept) begin
            s_d.a_busy  = 1'b1;
            s_d.a_first = 1'b1;
            s_d.a_addr  = req_addr;
            s_d.a_kind  = req_kind;
            s_d.a_write = req_write;
            s_d.a_dw    = req_dw;
            s_d.a_len   = req_len;
        end else if (s_q.a_busy && aack) begin
            s_d.a_busy = 1'b0;
            if (s_q.a_kind[KIND_AONLY_BIT]) begin
                s_d.adone = 1'b1;
            end else if (!s_q.d_busy && !s_q.pend_v) begin
                s_d.dat    = plan_t;
                s_d.d_busy = 1'b1;
            end else begin
                s_d.pend   = plan_t;
                s_d.pend_v = 1'b1;
            end
        end

        // data tenure
        if (s_q.d_busy && ta) begin
            if (s_q.dat.left == CW'(1)) begin
                s_d.d_busy = 1'b0;
                s_d.ddone  = 1'b1;
            end else begin
                s_d.dat.left = s_q.dat.left - CW'(1);
                s_d.dat.addr = step_addr;
            end
        end else if (!s_q.d_busy && s_q.pend_v) begin
            s_d.dat    = s_q.pend;
            s_d.d_busy = 1'b1;
            s_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.wide <= width_sel;
        end else begin
            s_q <= s_d;
        end
    end

    assign ts       = s_q.a_first;
    assign a_addr   = s_q.a_addr;
    assign a_kind   = s_q.a_kind;
    assign a_write  = s_q.a_write;
    assign d_active = s_q.d_busy;
    assign d_addr   = s_q.dat.addr;
    assign d_bytes  = s_q.dat.bytes;
    assign d_write  = s_q.dat.write;
    assign ddone    = s_q.ddone;
    assign adone    = s_q.adone;
endmodule

// File: rtl/bus_beat_seq_chk.sv
module bus_beat_seq_chk #(
    parameter int LINE_BYTES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wide_q,
    input logic       req_valid,
    input logic       req_ready,
    input logic       ts,
    input logic       aack,
    input logic       d_active,
    input logic [3:0] d_bytes,
    input logic       ta,
    input logic       ddone,
    input logic       adone
);
    logic [7:0] beat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (ddone) begin
            beat_cnt <= '0;
        end else if (d_active && ta) begin
            beat_cnt <= beat_cnt + 8'd1;
        end
    end

    a_r1_width_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(wide_q));

    a_r2_beat_size: assert property (@(posedge clk) disable iff (!rst_n)
        d_active |-> (d_bytes >= 4'd1 &&
                      (d_bytes <= 4'd4 || (wide_q && d_bytes == 4'd8))));

    // R3 and R4: a finished tenure has a count that the width allows
    a_r3_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
        ddone |-> (wide_q ? (beat_cnt == 8'd1 || beat_cnt == 8'(LINE_BYTES / 8))
                          : (beat_cnt == 8'd1 || beat_cnt == 8'd2 ||
                             beat_cnt == 8'(LINE_BYTES / 4))));

    a_r6_aonly_after_aack: assert property (@(posedge clk) disable iff (!rst_n)
        adone |-> $past(aack));

    a_r7_ts_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ts);

    a_r7_ts_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ts |=> !ts);

    a_r9_reserve_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (aack && !ts && d_active && !req_ready) |=> !req_ready);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ddone |-> !d_active);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ddone |=> !ddone);
endmodule

bind bus_beat_seq bus_beat_seq_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_q    (s_q.wide),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ts        (ts),
    .aack      (aack),
    .d_active  (d_active),
    .d_bytes   (d_bytes),
    .ta        (ta),
    .ddone     (ddone),
    .adone     (adone)
);

// File: tb/tb_bus_beat_seq.sv
`timescale 1ns/1ps
module tb_bus_beat_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_sel = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_dw = 1'b0;
    logic [1:0]  req_len = 2'd0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ts;
    logic [31:0] a_addr;
    logic [1:0]  a_kind;
    logic        a_write;
    logic        aack = 1'b0;
    logic        d_active;
    logic [31:0] d_addr;
    logic [3:0]  d_bytes;
    logic        d_write;
    logic        ta = 1'b0;
    logic        ddone;
    logic        adone;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_beat_seq dut (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_dw(req_dw), .req_len(req_len), .req_write(req_write),
        .req_addr(req_addr), .ts(ts), .a_addr(a_addr), .a_kind(a_kind),
        .a_write(a_write), .aack(aack), .d_active(d_active), .d_addr(d_addr),
        .d_bytes(d_bytes), .d_write(d_write), .ta(ta), .ddone(ddone),
        .adone(adone)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_beats(input bit w, input logic [1:0] k, input bit dw);
        if (k[1]) return 0;
        if (k == 2'd1) return w ? 4 : 8;
        return (dw && !w) ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_addr(input bit w, input logic [1:0] k,
                                             input bit dw, input logic [31:0] a, input int i);
        int step;
        logic [31:0] first;
        logic [4:0] lo;
        step = w ? 8 : 4;
        if (k == 2'd1) first = a & ~32'(step - 1);
        else if (dw) first = a & ~32'd7;
        else return a;
        lo = 5'(first[4:0] + i * step);
        return {a[31:5], lo};
    endfunction

    function automatic int exp_bytes(input bit w, input logic [1:0] k, input bit dw,
                                     input logic [1:0] len);
        if (k == 2'd1 || dw) return w ? 8 : 4;
        return int'(len) + 1;
    endfunction

    // called at the negedge where the first beat is expected
    task automatic run_beats(input bit w, input logic [1:0] k, input bit dw,
                             input logic [1:0] len, input bit wr, input logic [31:0] a);
        int n;
        n = exp_beats(w, k, dw);
        for (int i = 0; i < n; i++) begin
            chk(d_active == 1'b1, "R3/R4 beat active", d_active, 1);
            chk(d_addr == exp_addr(w, k, dw, a, i), "R5 beat address", d_addr, exp_addr(w, k, dw, a, i));
            chk(int'(d_bytes) == exp_bytes(w, k, dw, len), "R2 beat bytes", d_bytes, exp_bytes(w, k, dw, len));
            chk(d_write == wr, "R2 beat direction", d_write, wr);
            ta = 1'b1;
            @(negedge clk);
        end
        ta = 1'b0;
        chk(ddone == 1'b1, "R10 done after last beat", ddone, 1);
        chk(d_active == 1'b0, "R3/R4 no extra beat", d_active, 0);
        @(negedge clk);
        chk(ddone == 1'b0, "R10 done one cycle", ddone, 0);
    endtask

    task automatic xfer(input bit w, input logic [1:0] k, input bit dw,
                        input logic [1:0] len, input bit wr, input logic [31:0] a);
        chk(req_ready == 1'b1, "R7 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_kind = k; req_dw = dw; req_len = len;
        req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ts == 1'b1, "R7 start pulse", ts, 1);
        chk(a_addr == a, "R7 address tenure address", a_addr, a);
        chk(a_kind == k, "R7 address tenure kind", a_kind, k);
        aack = 1'b1;
        @(negedge clk);
        aack = 1'b0;
        chk(ts == 1'b0, "R7 start pulse one cycle", ts, 0);
        if (k[1]) begin
            chk(adone == 1'b1, "R6 address-only done", adone, 1);
            chk(d_active == 1'b0, "R6 no data tenure", d_active, 0);
            @(negedge clk);
            chk(adone == 1'b0 && d_active == 1'b0, "R6 pulse and idle", {adone, d_active}, 0);
        end else begin
            run_beats(w, k, dw, len, wr, a);
        end
    endtask

    task automatic do_reset(input bit w);
        rst_n = 1'b0;
        width_sel = w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        width_sel = ~w; // strap change after release must be ignored (R1)
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        chk({ts, d_active, ddone, adone} == 4'b0, "R11 outputs idle after reset",
            {ts, d_active, ddone, adone}, 0);
    endtask

    task automatic overlap(input bit w);
        logic [31:0] aa, ba;
        aa = 32'h0000_4a14;
        ba = 32'h0000_9c08;
        // first request: a line
        req_valid = 1'b1; req_kind = 2'd1; req_dw = 1'b0; req_len = 2'd0;
        req_write = 1'b0; req_addr = aa;
        @(negedge clk);
        req_valid = 1'b0;
        aack = 1'b1;
        @(negedge clk);
        aack = 1'b0;
        chk(d_active == 1'b1, "R8 first data tenure open", d_active, 1);
        chk(req_ready == 1'b1, "R8 ready during data tenure", req_ready, 1);
        req_valid = 1'b1; req_kind = 2'd0; req_dw = 1'b1; req_write = 1'b1; req_addr = ba;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ts == 1'b1 && d_active == 1'b1, "R8 address tenure overlaps data", {ts, d_active}, 2'b11);
        chk(a_addr == ba, "R8 overlapped address", a_addr, ba);
        aack = 1'b1;
        @(negedge clk);
        aack = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low with reserve held", req_ready, 0);
        chk(d_addr == exp_addr(w, 2'd1, 1'b0, aa, 0), "R9 first tenure undisturbed",
            d_addr, exp_addr(w, 2'd1, 1'b0, aa, 0));
        run_beats(w, 2'd1, 1'b0, 2'd0, 1'b0, aa);
        // run_beats ends one cycle after ddone: the reserve must be running now
        chk(d_addr == exp_addr(w, 2'd0, 1'b1, ba, 0), "R9 reserve starts after done",
            d_addr, exp_addr(w, 2'd0, 1'b1, ba, 0));
        run_beats(w, 2'd0, 1'b1, 2'd0, 1'b1, ba);
        chk(req_ready == 1'b1, "R9 ready after reserve drained", req_ready, 1);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int wi = 0; wi < 2; wi++) begin
            bit w;
            w = (wi == 1);
            do_reset(w);
            // noncached single beats, every length and several alignments
            for (int len = 0; len < 4; len++)
                for (int off = 0; off < 32; off += 5)
                    xfer(w, 2'd0, 1'b0, 2'(len), off[0], 32'h1000_0000 + 32'(off) + 32'(len * 64));
            // noncached double-word
            for (int off = 0; off < 32; off += 4)
                xfer(w, 2'd0, 1'b1, 2'd0, off[2], 32'h2000_0100 + 32'(off));
            // line fills and writebacks from every word offset (R3, R5)
            for (int off = 0; off < 32; off += 4) begin
                xfer(w, 2'd1, 1'b0, 2'd0, 1'b0, 32'h3000_0040 + 32'(off));
                xfer(w, 2'd1, 1'b0, 2'd0, 1'b1, 32'h3fff_ffe0 + 32'(off));
            end
            // address-only, both encodings (R6)
            xfer(w, 2'd2, 1'b0, 2'd0, 1'b0, 32'h4000_0000);
            xfer(w, 2'd3, 1'b1, 2'd3, 1'b1, 32'h4000_0020);
            overlap(w);
            // R1: strap flipped after reset, line count follows captured width
            width_sel = ~width_sel;
            @(negedge clk);
            xfer(w, 2'd1, 1'b0, 2'd0, 1'b0, 32'h5000_0018);
        end
        finish_run();
    end
endmodule